// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A free-running prescaler counts enable pulses from a 32.768 kHz oscillator domain. Each time it wraps, the block advances the seconds field and carries through the whole calendar. The hours byte holds either a 24-hour value or a 12-hour value with a PM flag. Month lengths and leap years are worked out from the stored month and year.

Software loads any field through a single-cycle write port. Every field is presented in parallel on the outputs. A control bit can halt timekeeping. An oscillator-stop flag records any stop, whether it came from that bit or from the oscillator-running status input going low. The flag stays set until software clears it. A one-cycle `tick_1hz` pulse marks each advance of the seconds field for neighbouring logic.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds and minutes read 0x00, hours 0x00 (24-hour midnight), day of week 0x01, day of month 0x01, month 0x01, year 0x00, the stop control reads 0, the stop flag reads 1 and `tick_1hz` is 0.
- R2: While running, every 2**PRESCALE_W accepted `osc_en` pulses give one advance. `tick_1hz` is high for exactly one cycle, in the cycle when the new seconds value first appears.
- R3: Seconds and minutes count 00 to 59 in BCD. Seconds wrap to 00 and carry into minutes; minutes wrap to 00 and carry into hours.
- R4: With hours bit 6 = 0 (24-hour), bits 5:0 count BCD 00 to 23. The step from 23 to 00 is the day boundary.
- R5: With hours bit 6 = 1 (12-hour), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The order is 12, 1..11 with the flag unchanged. The step 11 to 12 flips PM, and 11 PM to 12 AM is the day boundary.
- R6: At a day boundary the day of month goes to 01 after 28 (February, common year), 29 (February, year divisible by 4, including 00), 30 (months 04, 06, 09, 11) or 31 (other months), and otherwise increments. Rolling to 01 carries into the month.
- R7: Month (bits 4:0) counts BCD 01 to 12; 12 wraps to 01 and carries into the year. Year counts BCD 00 to 99. The step 99 to 00 inverts month bit 7, the century flag.
- R8: The day of week (low 3 bits) advances at each day boundary and goes from 7 to 1.
- R9: A write to the seconds address clears the prescaler, so the next advance needs a full 2**PRESCALE_W pulses. In a cycle that writes any of addresses 0 to 6, there is no advance and no `tick_1hz`.
- R10: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 control (bit 7 = stop), 8 status (bit 7 = stop flag). Stored data is masked with 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x9F and 0xFF for addresses 0 to 6. Addresses 9 to 15 change nothing.
- R11: While the stop control is 1 or `osc_ok` is 0, the prescaler and all time fields hold.
- R12: The stop flag goes to 1 on the cycle after running turns into not-running. It is cleared by writing status bit 7 as 0. Writing status bit 7 as 1 leaves it as it is, and a new stop takes priority over a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| osc_ok | input | 1 | Oscillator running status |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours with mode and PM bits |
| dow | output | 8 | Day of week |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD, with century flag in bit 7 |
| year | output | 8 | Year, BCD |
| eosc | output | 1 | Stop control bit |
| osf | output | 1 | Oscillator-stop flag |
| tick_1hz | output | 1 | One-cycle pulse per seconds advance |

## Verification
The bench builds the block with PRESCALE_W = 2, so four accepted enable pulses make a second. With enables gated at two of every three cycles, a simulated second takes about six clocks. This shortening lets the bench reach minute, hour, midnight, month-end, leap-February, year and century boundaries in a few hundred cycles. With it, a seconds write landing between enables visibly restarts the count. The ADDR_W default of 4 leaves the unused addresses 9 to 15 reachable, so the bench can confirm they have no effect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef logic [7:0] bcd8_t;

   typedef enum logic [3:0] {
      RA_SEC   = 4'd0,
      RA_MIN   = 4'd1,
      RA_HOUR  = 4'd2,
      RA_DOW   = 4'd3,
      RA_DATE  = 4'd4,
      RA_MONTH = 4'd5,
      RA_YEAR  = 4'd6,
      RA_CTRL  = 4'd7,
      RA_STAT  = 4'd8
   } reg_addr_e;

   // increment of a two-digit packed BCD value, no range wrap
   function automatic bcd8_t bcd_inc(input bcd8_t v);
      if (v[3:0] == 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic step_en,
   input  logic clear,
   output logic wrap
);
   generate
      if (W < 1) begin : g_bad_width
         $error("rtc_prescaler: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && step_en)
         cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = run && step_en && !clear && (cnt_q == '1);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
(
   input  bcd8_t sec_q,
   input  bcd8_t min_q,
   input  bcd8_t hour_q,
   output bcd8_t sec_d,
   output bcd8_t min_d,
   output bcd8_t hour_d,
   output logic  day_carry
);
   bcd8_t inc12, inc24;

   always_comb begin
      inc12     = bcd_inc({3'b000, hour_q[4:0]});
      inc24     = bcd_inc({2'b00, hour_q[5:0]});
      sec_d     = (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      min_d     = min_q;
      hour_d    = hour_q;
      day_carry = 1'b0;
      if (sec_q == 8'h59) begin
         min_d = (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
         if (min_q == 8'h59) begin
            if (hour_q[6]) begin
               // 12-hour encoding: flag flips on 11 -> 12
               case (hour_q[4:0])
                  5'h11: begin
                     hour_d    = {hour_q[7:6], ~hour_q[5], 5'h12};
                     day_carry = hour_q[5];
                  end
                  5'h12:   hour_d = {hour_q[7:5], 5'h01};
                  default: hour_d = {hour_q[7:5], inc12[4:0]};
               endcase
            end else begin
               if (hour_q[5:0] == 6'h23) begin
                  hour_d    = {hour_q[7:6], 6'h00};
                  day_carry = 1'b1;
               end else begin
                  hour_d = {hour_q[7:6], inc24[5:0]};
               end
            end
         end
      end
   end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
   import rtc_pkg::*;
(
   input  bcd8_t dow_q,
   input  bcd8_t date_q,
   input  bcd8_t month_q,
   input  bcd8_t year_q,
   output bcd8_t dow_d,
   output bcd8_t date_d,
   output bcd8_t month_d,
   output bcd8_t year_d
);
   logic [4:0] mod4_sum;
   logic       leap;
   bcd8_t      last_day;
   bcd8_t      mon_next;

   always_comb begin
      // year mod 4 from packed digits: (2*tens + units) mod 4
      mod4_sum = {year_q[7:4], 1'b0} + {1'b0, year_q[3:0]};
      leap     = (mod4_sum[1:0] == 2'b00);
      case (month_q[4:0])
         5'h02:                      last_day = leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase

      dow_d    = (dow_q[2:0] == 3'd7) ? 8'h01 : bcd_inc(dow_q);
      date_d   = bcd_inc(date_q);
      month_d  = month_q;
      year_d   = year_q;
      mon_next = bcd_inc({3'b000, month_q[4:0]});
      if (date_q == last_day) begin
         date_d = 8'h01;
         if (month_q[4:0] == 5'h12) begin
            if (year_q == 8'h99) begin
               year_d  = 8'h00;
               month_d = {~month_q[7], 2'b00, 5'h01};
            end else begin
               year_d  = bcd_inc(year_q);
               month_d = {month_q[7], 2'b00, 5'h01};
            end
         end else begin
            month_d = {month_q[7], 2'b00, mon_next[4:0]};
         end
      end
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int PRESCALE_W = 15,
   parameter int ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              osc_ok,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        sec,
   output logic [7:0]        min,
   output logic [7:0]        hour,
   output logic [7:0]        dow,
   output logic [7:0]        date,
   output logic [7:0]        month,
   output logic [7:0]        year,
   output logic              eosc,
   output logic              osf,
   output logic              tick_1hz
);
   localparam int NUM_TIME_REGS = 7;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("rtc_calendar: ADDR_W must be at least 4");
      end
   endgenerate

   bcd8_t sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
   bcd8_t sec_d, min_d, hour_d, dow_d, date_d, month_d, year_d;
   logic  day_carry, running, run_q, wrap, time_wr, advance;
   logic  wr_sec, wr_ctrl, wr_stat;

   assign running = !eosc && osc_ok;
   assign time_wr = wr_en && (wr_addr < ADDR_W'(NUM_TIME_REGS));
   assign wr_sec  = wr_en && (wr_addr == ADDR_W'(RA_SEC));
   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(RA_CTRL));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(RA_STAT));
   assign advance = wrap && !time_wr;

   rtc_prescaler #(.W(PRESCALE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(running), .step_en(osc_en),
      .clear(wr_sec), .wrap(wrap)
   );

   rtc_time_chain u_time (
      .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
      .sec_d(sec_d), .min_d(min_d), .hour_d(hour_d), .day_carry(day_carry)
   );

   rtc_date_chain u_date (
      .dow_q(dow_q), .date_q(date_q), .month_q(month_q), .year_q(year_q),
      .dow_d(dow_d), .date_d(date_d), .month_d(month_d), .year_d(year_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q   <= 8'h00;
         min_q   <= 8'h00;
         hour_q  <= 8'h00;
         dow_q   <= 8'h01;
         date_q  <= 8'h01;
         month_q <= 8'h01;
         year_q  <= 8'h00;
      end else if (time_wr) begin
         case (wr_addr[2:0])
            3'd0:    sec_q   <= wr_data & 8'h7F;
            3'd1:    min_q   <= wr_data & 8'h7F;
            3'd2:    hour_q  <= wr_data & 8'h7F;
            3'd3:    dow_q   <= wr_data & 8'h07;
            3'd4:    date_q  <= wr_data & 8'h3F;
            3'd5:    month_q <= wr_data & 8'h9F;
            default: year_q  <= wr_data;
         endcase
      end else if (advance) begin
         sec_q  <= sec_d;
         min_q  <= min_d;
         hour_q <= hour_d;
         if (day_carry) begin
            dow_q   <= dow_d;
            date_q  <= date_d;
            month_q <= month_d;
            year_q  <= year_d;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eosc     <= 1'b0;
         osf      <= 1'b1;
         run_q    <= 1'b0;
         tick_1hz <= 1'b0;
      end else begin
         run_q    <= running;
         tick_1hz <= advance;
         if (wr_ctrl)
            eosc <= wr_data[7];
         if (run_q && !running)
            osf <= 1'b1;
         else if (wr_stat && !wr_data[7])
            osf <= 1'b0;
      end
   end

   assign sec   = sec_q;
   assign min   = min_q;
   assign hour  = hour_q;
   assign dow   = dow_q;
   assign date  = date_q;
   assign month = month_q;
   assign year  = year_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              osc_ok,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        sec,
   input logic [7:0]        min,
   input logic [7:0]        hour,
   input logic [7:0]        date,
   input logic [7:0]        month,
   input logic [7:0]        year,
   input logic              eosc,
   input logic              osf,
   input logic              tick_1hz
);
   assert_tick_moves_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |-> (sec != $past(sec)));

   assert_tick_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |=> !tick_1hz);

   assert_write_blocks_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr < ADDR_W'(7))) |=> !tick_1hz);

   assert_stopped_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((eosc || !osc_ok) && !wr_en) |=>
         ($stable(sec) && $stable(min) && $stable(hour) && $stable(date)));

   assert_flag_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osf) |-> ($past(eosc) || !$past(osc_ok)));

   assert_century_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(month[7]) && !$past(wr_en)) |-> (year == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .osc_ok(osc_ok), .wr_en(wr_en), .wr_addr(wr_addr),
   .sec(sec), .min(min), .hour(hour), .date(date), .month(month), .year(year),
   .eosc(eosc), .osf(osf), .tick_1hz(tick_1hz)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
   localparam int PW   = 2;
   localparam int PMAX = (1 << PW) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0;
   logic       osc_ok = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = 4'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] sec, min, hour, dow, date, month, year;
   logic       eosc, osf, tick_1hz;

   always #2 clk = ~clk;

   rtc_calendar #(.PRESCALE_W(PW), .ADDR_W(4)) u_rtc_calendar (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_ok(osc_ok),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date),
      .month(month), .year(year), .eosc(eosc), .osf(osf), .tick_1hz(tick_1hz)
   );

   int    n_vec = 0, n_bad = 0, cyc = 0;
   bit    en_on = 1'b0;
   string phase = "R1 reset";

   // behavioural reference model
   int m_sec, m_min, m_h, m_dow, m_date, m_mon, m_year, m_p;
   bit m_12, m_pm, m_cent, m_eosc, m_osf, m_runq, m_tick;

   function automatic int b2i(input logic [7:0] b);
      return b[7:4] * 10 + b[3:0];
   endfunction
   function automatic logic [7:0] i2b(input int n);
      return 8'((n / 10) * 16 + (n % 10));
   endfunction
   function automatic int dim(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_advance();
      bit day;
      day = 0;
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0;
            if (m_12) begin
               if (m_h == 11) begin m_h = 12; m_pm = !m_pm; day = !m_pm; end
               else if (m_h == 12) m_h = 1;
               else m_h++;
            end else begin
               if (m_h == 23) begin m_h = 0; day = 1; end
               else m_h++;
            end
         end
      end
      if (day) begin
         m_dow = (m_dow == 7) ? 1 : m_dow + 1;
         if (m_date == dim(m_mon, m_year)) begin
            m_date = 1;
            if (m_mon == 12) begin
               m_mon = 1;
               if (m_year == 99) begin m_year = 0; m_cent = !m_cent; end
               else m_year++;
            end else m_mon++;
         end else m_date++;
      end
   endtask

   task automatic model_write(input int a, input logic [7:0] d);
      logic [7:0] v;
      case (a)
         0: m_sec = b2i(d & 8'h7F);
         1: m_min = b2i(d & 8'h7F);
         2: begin
            v = d & 8'h7F;
            m_12 = v[6];
            if (m_12) begin m_pm = v[5]; m_h = b2i({3'b000, v[4:0]}); end
            else begin m_pm = 0; m_h = b2i({2'b00, v[5:0]}); end
         end
         3: m_dow = int'(d & 8'h07);
         4: m_date = b2i(d & 8'h3F);
         5: begin m_cent = d[7]; m_mon = b2i({3'b000, d[4:0]}); end
         default: m_year = b2i(d);
      endcase
   endtask

   always @(posedge clk) begin
      bit run, tw, wrap;
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_h = 0; m_12 = 0; m_pm = 0; m_dow = 1; m_date = 1;
         m_mon = 1; m_year = 0; m_cent = 0; m_p = 0; m_eosc = 0; m_osf = 1;
         m_runq = 0; m_tick = 0;
      end else begin
         run  = !m_eosc && osc_ok;
         tw   = wr_en && (wr_addr <= 4'd6);
         wrap = 0;
         if (wr_en && wr_addr == 4'd0) m_p = 0;
         else if (run && osc_en) begin
            if (m_p == PMAX) begin m_p = 0; wrap = 1; end
            else m_p++;
         end
         if (tw) model_write(int'(wr_addr), wr_data);
         else if (wrap) model_advance();
         m_tick = wrap && !tw;
         if (m_runq && !run) m_osf = 1;
         else if (wr_en && wr_addr == 4'd8 && !wr_data[7]) m_osf = 0;
         if (wr_en && wr_addr == 4'd7) m_eosc = wr_data[7];
         m_runq = run;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] at cycle %0d: actual %h expected %h", tag, phase, cyc, act, exp);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      logic [7:0] eh;
      cyc++;
      eh = m_12 ? (8'h40 | (m_pm ? 8'h20 : 8'h00) | i2b(m_h)) : i2b(m_h);
      n_vec++;
      chk("R3 seconds", sec, i2b(m_sec));
      chk("R3 minutes", min, i2b(m_min));
      chk("R4 R5 hours", hour, eh);
      chk("R8 weekday", dow, 8'(m_dow));
      chk("R6 date", date, i2b(m_date));
      chk("R7 month", month, (m_cent ? 8'h80 : 8'h00) | i2b(m_mon));
      chk("R7 year", year, i2b(m_year));
      chk("R11 stop", {7'd0, eosc}, {7'd0, m_eosc});
      chk("R12 flag", {7'd0, osf}, {7'd0, m_osf});
      chk("R2 tick", {7'd0, tick_1hz}, {7'd0, m_tick});
      osc_en = en_on && (cyc % 3 != 1);
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [7:0] dw, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr);
      en_on = 1'b0;
      wr(2, h); wr(1, mi); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr); wr(0, s);
      en_on = 1'b1;
   endtask

   initial begin
      run_n(3);
      rst_n = 1'b1;
      run_n(2);

      phase = "R12 clear"; wr(8, 8'h80); run_n(1); wr(8, 8'h00); run_n(2);

      phase = "R2 prescale"; en_on = 1'b1; run_n(40);

      phase = "R10 masks"; en_on = 1'b0;
      wr(0, 8'hD9); wr(3, 8'hF3); wr(5, 8'h92); wr(9, 8'h55); wr(15, 8'h00); run_n(3);

      phase = "R3 rollover";  set_time(8'h10, 8'h58, 8'h57, 8'h02, 8'h10, 8'h03, 8'h21); run_n(30);
      phase = "R4 R8 midnight"; set_time(8'h23, 8'h59, 8'h58, 8'h07, 8'h15, 8'h06, 8'h24); run_n(20);
      phase = "R5 11pm";      set_time(8'h71, 8'h59, 8'h58, 8'h03, 8'h05, 8'h05, 8'h25); run_n(20);
      phase = "R5 11am";      set_time(8'h51, 8'h59, 8'h58, 8'h03, 8'h05, 8'h05, 8'h25); run_n(20);
      phase = "R5 12am";      set_time(8'h52, 8'h59, 8'h58, 8'h03, 8'h05, 8'h05, 8'h25); run_n(20);
      phase = "R6 feb common"; set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23); run_n(12);
      phase = "R6 feb leap";  set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24); run_n(12);
      phase = "R6 feb 29";    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24); run_n(12);
      phase = "R6 year 00";   set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00); run_n(12);
      phase = "R6 april";     set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h24); run_n(12);
      phase = "R6 may";       set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h24); run_n(12);
      phase = "R7 century";   set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99); run_n(12);
      phase = "R7 century back"; set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h92, 8'h99); run_n(12);
      phase = "R7 year step"; set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h41); run_n(12);

      phase = "R9 seconds write";
      run_n(2); wr(0, 8'h30); run_n(3); wr(0, 8'h30); run_n(10);
      repeat (6) wr(1, 8'h05);
      run_n(8);

      phase = "R11 stop bit"; wr(7, 8'h80); run_n(20); wr(8, 8'h00); wr(7, 8'h00); run_n(10);
      phase = "R11 osc lost"; osc_ok = 1'b0; run_n(10); osc_ok = 1'b1; run_n(10);
      phase = "R12 write one"; wr(8, 8'h80); run_n(2); wr(8, 8'h00); run_n(5);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule